// File: doc/BRIEF.md
# PLL Enable/Disable Sequencer

This block brings one PLL up or down by issuing a fixed series of register transactions to the PLL register bank. It is a bus master on that bank. A start request first selects the PLL index and reads back the current divider, multiplier and lock status. If the PLL is already locked at the wanted divider and multiplier, the sequence ends there. If not, the block programs the analog control word and the multiplier. For a USB-PHY-type PLL it then turns on the bandgap, waits 10 µs, turns on the regulator and waits 10 µs more. After that it commits, writes the enable word with the divider, commits again, and polls the lock flag until it is set. A programmable limit on the lock wait raises an error if the flag never appears.

A stop request runs the reverse order. It selects the index and reads control word 0. It clears the output enable and commits. It then clears the PLL enable and, for a USB-PHY-type PLL, reads the analog word and clears both analog enables. A final commit ends the sequence. Working out the divider and multiplier is left to the requester, which drives them as targets with the start pulse.

The bus side is a request channel with valid/ready and a response channel with valid only. A request holds its payload until ready is seen. After a read request has been accepted, the block waits for exactly one response beat before it issues anything else. The response channel has no back-pressure: the block is always able to take the beat.

Top module: `pll_seq_ctrl`

## Requirements
- R1: On start while idle, the first bus transaction is a write of the PLL index to the select register (address 0). The index, type flag, targets and timeout are captured at that moment.
- R2: After the select write, the block reads control word 0 (address 1, divider in bits 7:0), then control word 1 (address 2, multiplier in bits 6:0), then status (address 5, lock of PLL i in bit i). If the selected lock bit is set and both fields equal the targets, it ends with done and issues no write.
- R3: If the early-exit test fails, the block writes the analog default (parameter, 0x500) to address 3 and then the multiplier alone to address 2. A PLL that is not USB-PHY type goes straight on to the commit.
- R4: For a USB-PHY-type PLL, the block next writes the analog default with bit 0 (bandgap) set. After at least 10 µs, counted as CYC_PER_US×10 clocks, it writes the default with bits 0 and 1 (regulator) set. It waits at least as long again before the next transaction.
- R5: The block then writes 1 to the commit register (address 4). It writes control word 0 with bit 24 (lock detect), bit 25 (PLL enable), bit 26 (output enable) and the divider. It then writes the commit register again.
- R6: The block then reads status repeatedly and pulses done only after a read returns the selected lock bit set.
- R7: If the lock bit is still clear on a poll once lock_timeout clocks have passed since polling began, the block pulses lock_err instead of done and returns to idle, where it accepts a new start.
- R8: On stop while idle, the block does: select write; read of control word 0; write of that value with bit 26 cleared; commit; write with bits 25 and 26 cleared; for USB-PHY type only, a read of address 3 and a write of it with bits 0 and 1 cleared; commit; done.
- R9: busy is high from the clock after an accepted request until the sequence ends. Start and stop pulses that arrive while busy have no effect. No bus request is made while idle. Start wins when start and stop arrive together.
- R10: A request with valid high and ready low keeps valid, address, write flag and data unchanged in the next cycle. At most one read is outstanding.
- R11: done and lock_err are single-cycle pulses, never high together, and appear in the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Bring-up request pulse |
| stop | input | 1 | Shutdown request pulse |
| pll_sel | input | IDX_W | PLL index to act on |
| phy_type | input | 1 | 1 = USB-PHY-type PLL with analog ramp |
| tgt_div | input | 8 | Wanted divider field |
| tgt_mul | input | 7 | Wanted multiplier field |
| lock_timeout | input | TMO_W | Lock wait limit in clocks |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished pulse |
| lock_err | output | 1 | Lock wait expired pulse |
| bus_valid | output | 1 | Request valid |
| bus_ready | input | 1 | Request accepted by bank |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 4 | Register address |
| bus_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read data beat |
| rsp_data | input | 32 | Read data |

## Verification
The hardest condition to reach from the ports is a start that finds the PLL locked with a multiplier that does not match the target. The decision then depends on all three read-backs taken together. The bench first brings the PLL up, so the bank model holds that divider and a lock, and then restarts with only the multiplier changed. Stalled requests and late responses are produced by a ready pattern and a response delay in the bank model. Stray start and stop pulses are injected in the middle of the 10 µs analog waits.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int DIV_W  = 8;
  localparam int MUL_W  = 7;

  localparam logic [ADDR_W-1:0] A_SEL    = 4'd0;
  localparam logic [ADDR_W-1:0] A_CFG0   = 4'd1;
  localparam logic [ADDR_W-1:0] A_CFG1   = 4'd2;
  localparam logic [ADDR_W-1:0] A_ANA    = 4'd3;
  localparam logic [ADDR_W-1:0] A_COMMIT = 4'd4;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd5;

  localparam logic [DATA_W-1:0] M_LDET = DATA_W'(1) << 24;
  localparam logic [DATA_W-1:0] M_PEN  = DATA_W'(1) << 25;
  localparam logic [DATA_W-1:0] M_OEN  = DATA_W'(1) << 26;
  localparam logic [DATA_W-1:0] M_BG   = DATA_W'(1) << 0;
  localparam logic [DATA_W-1:0] M_VR   = DATA_W'(1) << 1;

  typedef enum logic [4:0] {
    S_IDLE, S_SEL, S_RDDIV, S_RDMUL, S_RDLOCK,
    S_WANA, S_WMUL, S_WBG, S_WAITBG, S_WVR, S_WAITVR,
    S_CMTA, S_WEN, S_CMTB, S_POLL,
    S_XSEL, S_XRD0, S_XOFFO, S_XCMTA, S_XOFFP, S_XRDANA, S_XWANA, S_XCMTB
  } seq_state_e;
endpackage

// File: rtl/pllseq_timer.sv
module pllseq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         cnt_zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/pllseq_bus_port.sv
module pllseq_bus_port #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_req,
  input  logic          op_we,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  output logic          op_done,
  output logic [DW-1:0] op_rdata,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data
);
  typedef enum logic [1:0] {P_IDLE, P_REQ, P_RSP} port_state_e;
  port_state_e pst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pst <= P_IDLE;
    else begin
      case (pst)
        P_IDLE: if (op_req) pst <= P_REQ;
        P_REQ:  if (bus_ready) pst <= op_we ? P_IDLE : P_RSP;
        P_RSP:  if (rsp_valid) pst <= P_IDLE;
        default: pst <= P_IDLE;
      endcase
    end
  end

  assign bus_valid = (pst == P_REQ);
  assign bus_we    = op_we;
  assign bus_addr  = op_addr;
  assign bus_wdata = op_wdata;
  assign op_rdata  = rsp_data;
  assign op_done   = ((pst == P_REQ) && bus_ready && op_we) ||
                     ((pst == P_RSP) && rsp_valid);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R10
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (pst == P_RSP) |-> !bus_valid); // R10
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pllseq_pkg::*;
#(
  parameter int CYC_PER_US = 200,
  parameter int WAIT_US    = 10,
  parameter int TMO_W      = 16,
  parameter int IDX_W      = 1,
  parameter logic [31:0] ANA_DEFAULT = 32'h0000_0500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [IDX_W-1:0]  pll_sel,
  input  logic              phy_type,
  input  logic [7:0]        tgt_div,
  input  logic [6:0]        tgt_mul,
  input  logic [TMO_W-1:0]  lock_timeout,
  output logic              busy,
  output logic              done,
  output logic              lock_err,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_we,
  output logic [3:0]        bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_data
);
  localparam int WAIT_CYC = CYC_PER_US * WAIT_US;
  localparam int WAIT_BW  = $clog2(WAIT_CYC + 1);
  localparam int TW       = (TMO_W > WAIT_BW) ? TMO_W : WAIT_BW;

  seq_state_e st, st_nx;
  logic [IDX_W-1:0]  idx_q;
  logic              phy_q;
  logic [DIV_W-1:0]  div_q;
  logic [MUL_W-1:0]  mul_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [DATA_W-1:0] shadow_q;
  logic [MUL_W-1:0]  cur_mul_q;

  logic              op_req, op_we, op_done;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata, op_rdata;
  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_val;
  logic              fin_ok, fin_err, lock_seen;

  assign lock_seen = op_rdata[idx_q];

  // Transaction issued in each bus state
  always_comb begin
    op_req   = 1'b1;
    op_we    = 1'b1;
    op_addr  = A_SEL;
    op_wdata = '0;
    case (st)
      S_SEL, S_XSEL: op_wdata = DATA_W'(idx_q);
      S_RDDIV, S_XRD0: begin op_we = 1'b0; op_addr = A_CFG0; end
      S_RDMUL:  begin op_we = 1'b0; op_addr = A_CFG1; end
      S_RDLOCK, S_POLL: begin op_we = 1'b0; op_addr = A_STAT; end
      S_WANA:   begin op_addr = A_ANA; op_wdata = ANA_DEFAULT; end
      S_WMUL:   begin op_addr = A_CFG1; op_wdata = {{(DATA_W-MUL_W){1'b0}}, mul_q}; end
      S_WBG:    begin op_addr = A_ANA; op_wdata = ANA_DEFAULT | M_BG; end
      S_WVR:    begin op_addr = A_ANA; op_wdata = ANA_DEFAULT | M_BG | M_VR; end
      S_CMTA, S_CMTB, S_XCMTA, S_XCMTB: begin op_addr = A_COMMIT; op_wdata = DATA_W'(1); end
      S_WEN:    begin
        op_addr  = A_CFG0;
        op_wdata = M_LDET | M_PEN | M_OEN | {{(DATA_W-DIV_W){1'b0}}, div_q};
      end
      S_XOFFO:  begin op_addr = A_CFG0; op_wdata = shadow_q & ~M_OEN; end
      S_XOFFP:  begin op_addr = A_CFG0; op_wdata = shadow_q & ~(M_OEN | M_PEN); end
      S_XRDANA: begin op_we = 1'b0; op_addr = A_ANA; end
      S_XWANA:  begin op_addr = A_ANA; op_wdata = shadow_q & ~(M_BG | M_VR); end
      default:  begin op_req = 1'b0; op_we = 1'b0; end
    endcase
  end

  // Sequencing
  always_comb begin
    st_nx    = st;
    fin_ok   = 1'b0;
    fin_err  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st)
      S_IDLE:   if (start) st_nx = S_SEL; else if (stop) st_nx = S_XSEL;
      S_SEL:    if (op_done) st_nx = S_RDDIV;
      S_RDDIV:  if (op_done) st_nx = S_RDMUL;
      S_RDMUL:  if (op_done) st_nx = S_RDLOCK;
      S_RDLOCK: if (op_done) begin
        if (lock_seen && shadow_q[DIV_W-1:0] == div_q && cur_mul_q == mul_q) begin
          st_nx = S_IDLE; fin_ok = 1'b1;
        end else st_nx = S_WANA;
      end
      S_WANA:   if (op_done) st_nx = S_WMUL;
      S_WMUL:   if (op_done) st_nx = phy_q ? S_WBG : S_CMTA;
      S_WBG:    if (op_done) begin st_nx = S_WAITBG; tmr_load = 1'b1; tmr_val = TW'(WAIT_CYC - 1); end
      S_WAITBG: if (tmr_zero) st_nx = S_WVR;
      S_WVR:    if (op_done) begin st_nx = S_WAITVR; tmr_load = 1'b1; tmr_val = TW'(WAIT_CYC - 1); end
      S_WAITVR: if (tmr_zero) st_nx = S_CMTA;
      S_CMTA:   if (op_done) st_nx = S_WEN;
      S_WEN:    if (op_done) st_nx = S_CMTB;
      S_CMTB:   if (op_done) begin st_nx = S_POLL; tmr_load = 1'b1; tmr_val = TW'(tmo_q); end
      S_POLL:   if (op_done) begin
        if (lock_seen)     begin st_nx = S_IDLE; fin_ok  = 1'b1; end
        else if (tmr_zero) begin st_nx = S_IDLE; fin_err = 1'b1; end
      end
      S_XSEL:   if (op_done) st_nx = S_XRD0;
      S_XRD0:   if (op_done) st_nx = S_XOFFO;
      S_XOFFO:  if (op_done) st_nx = S_XCMTA;
      S_XCMTA:  if (op_done) st_nx = S_XOFFP;
      S_XOFFP:  if (op_done) st_nx = phy_q ? S_XRDANA : S_XCMTB;
      S_XRDANA: if (op_done) st_nx = S_XWANA;
      S_XWANA:  if (op_done) st_nx = S_XCMTB;
      S_XCMTB:  if (op_done) begin st_nx = S_IDLE; fin_ok = 1'b1; end
      default:  st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx_q     <= '0;
      phy_q     <= 1'b0;
      div_q     <= '0;
      mul_q     <= '0;
      tmo_q     <= '0;
      shadow_q  <= '0;
      cur_mul_q <= '0;
      done      <= 1'b0;
      lock_err  <= 1'b0;
    end else begin
      st       <= st_nx;
      done     <= fin_ok;
      lock_err <= fin_err;
      if (st == S_IDLE && (start || stop)) begin
        idx_q <= pll_sel;
        phy_q <= phy_type;
        div_q <= tgt_div;
        mul_q <= tgt_mul;
        tmo_q <= lock_timeout;
      end
      if (op_done && (st == S_RDDIV || st == S_XRD0 || st == S_XRDANA)) shadow_q <= op_rdata;
      if (op_done && st == S_RDMUL) cur_mul_q <= op_rdata[MUL_W-1:0];
    end
  end

  assign busy = (st != S_IDLE);

  pllseq_bus_port #(.AW(ADDR_W), .DW(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .op_req(op_req), .op_we(op_we), .op_addr(op_addr), .op_wdata(op_wdata),
    .op_done(op_done), .op_rdata(op_rdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  pllseq_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .cnt_zero(tmr_zero)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_valid); // R9
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || lock_err) |-> !busy); // R11
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && lock_err)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_ERR_FROM_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |-> $past(st == S_POLL)); // R7
  AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAITBG || st == S_WAITVR) |-> !bus_valid); // R4
endmodule

// File: tb/test_pll_seq_ctrl.sv
module test_pll_seq_ctrl;
  localparam int WAITC = 2000;
  localparam logic [3:0] T_SEL = 0, T_C0 = 1, T_C1 = 2, T_ANA = 3, T_CMT = 4, T_ST = 5;
  localparam logic [31:0] ANA_D = 32'h500;
  localparam logic [31:0] EN3 = (32'h1 << 24) | (32'h1 << 25) | (32'h1 << 26);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stop = 1'b0;
  logic [0:0] pll_sel = '0;
  logic phy_type = 1'b0;
  logic [7:0] tgt_div = '0;
  logic [6:0] tgt_mul = '0;
  logic [15:0] lock_timeout = 16'd100;
  logic busy, done, lock_err, bus_valid, bus_we;
  logic bus_ready = 1'b1, rsp_valid = 1'b0;
  logic [3:0] bus_addr;
  logic [31:0] bus_wdata, rsp_data = '0;

  always #2.5 clk = ~clk;

  pll_seq_ctrl i_pll_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .pll_sel(pll_sel),
    .phy_type(phy_type), .tgt_div(tgt_div), .tgt_mul(tgt_mul), .lock_timeout(lock_timeout),
    .busy(busy), .done(done), .lock_err(lock_err),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  typedef struct { bit we; logic [3:0] a; logic [31:0] d; string tag; } txn_t;
  txn_t exp_q[$];
  int checks = 0, fails = 0;
  int cyc_n = 0, stall_mod = 0, lat = 1, rsp_cnt = 0, polls_to_lock = -1;
  bit skip_status = 0;
  logic [31:0] rsp_hold, cfg0_m = 0, cfg1_m = 0, ana_m = 0;
  logic [0:0] sel_m = 0;
  int t_bg = 0, t_vr = 0, t_cm = 0;
  int n_done = 0, n_err = 0;
  bit hold_chk = 0;
  logic [3:0] h_a;
  logic [31:0] h_d;

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic push(bit we, logic [3:0] a, logic [31:0] d, string tag);
    txn_t t;
    t.we = we; t.a = a; t.d = d; t.tag = tag;
    exp_q.push_back(t);
  endtask

  // Bank model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc_n++;
      bus_ready = (stall_mod == 0) || (cyc_n % stall_mod != 0);
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        rsp_valid = (rsp_cnt == 0);
        rsp_data  = rsp_hold;
      end else rsp_valid = 1'b0;
      #1;
      if (hold_chk) begin
        check(bus_valid && bus_addr == h_a && bus_wdata == h_d, "R10", "stalled request held",
              {bus_valid, bus_addr}, {1'b1, h_a});
        hold_chk = 0;
      end
      if (bus_valid && !bus_ready) begin
        hold_chk = 1; h_a = bus_addr; h_d = bus_wdata;
      end
      if (bus_valid && bus_ready) begin
        if (!(skip_status && !bus_we && bus_addr == T_ST)) begin
          if (exp_q.size() == 0)
            check(0, "R9", "unexpected transaction", {bus_we, bus_addr}, 0);
          else begin
            txn_t t;
            t = exp_q.pop_front();
            check(bus_we == t.we && bus_addr == t.a && (!t.we || bus_wdata == t.d), t.tag,
                  "transaction", {bus_we, bus_addr, bus_wdata}, {t.we, t.a, t.d});
          end
        end
        if (bus_we) begin
          case (bus_addr)
            T_SEL: sel_m = bus_wdata[0];
            T_C0:  cfg0_m = bus_wdata;
            T_C1:  cfg1_m = bus_wdata;
            T_ANA: begin
              ana_m = bus_wdata;
              if (bus_wdata[1:0] == 2'b01) t_bg = cyc_n;
              if (bus_wdata[1:0] == 2'b11) t_vr = cyc_n;
            end
            T_CMT: t_cm = cyc_n;
            default: ;
          endcase
        end else begin
          case (bus_addr)
            T_C0:  rsp_hold = cfg0_m;
            T_C1:  rsp_hold = cfg1_m;
            T_ANA: rsp_hold = ana_m;
            T_ST: begin
              rsp_hold = 32'h1 << (sel_m ^ 1'b1);
              if (polls_to_lock == 0) rsp_hold = rsp_hold | (32'h1 << sel_m);
              else if (polls_to_lock > 0) polls_to_lock--;
            end
            default: rsp_hold = 32'hdead;
          endcase
          rsp_cnt = lat;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (done) n_done++;
      if (lock_err) n_err++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic pulse(bit s, bit idx, bit usb, logic [7:0] dv, logic [6:0] ml, logic [15:0] tmo);
    @(negedge clk);
    start = s; stop = !s; pll_sel = idx; phy_type = usb; tgt_div = dv; tgt_mul = ml; lock_timeout = tmo;
    @(negedge clk);
    start = 0; stop = 0;
    check(busy == 1'b1, "R9", "busy after request", busy, 1);
  endtask

  task automatic exp_bringup(bit idx, bit usb, logic [7:0] dv, logic [6:0] ml, int npoll, bit with_stat);
    push(1, T_SEL, {31'h0, idx}, "R1");
    push(0, T_C0, 0, "R2");
    push(0, T_C1, 0, "R2");
    if (with_stat) push(0, T_ST, 0, "R2");
    push(1, T_ANA, ANA_D, "R3");
    push(1, T_C1, {25'h0, ml}, "R3");
    if (usb) begin
      push(1, T_ANA, ANA_D | 32'h1, "R4");
      push(1, T_ANA, ANA_D | 32'h3, "R4");
    end
    push(1, T_CMT, 32'h1, "R5");
    push(1, T_C0, EN3 | {24'h0, dv}, "R5");
    push(1, T_CMT, 32'h1, "R5");
    for (int i = 0; i < npoll; i++) push(0, T_ST, 0, "R6");
  endtask

  task automatic exp_shutdown(bit idx, bit usb);
    push(1, T_SEL, {31'h0, idx}, "R8");
    push(0, T_C0, 0, "R8");
    push(1, T_C0, cfg0_m & ~(32'h1 << 26), "R8");
    push(1, T_CMT, 32'h1, "R8");
    push(1, T_C0, cfg0_m & ~(32'h3 << 25), "R8");
    if (usb) begin
      push(0, T_ANA, 0, "R8");
      push(1, T_ANA, ana_m & ~32'h3, "R8");
    end
    push(1, T_CMT, 32'h1, "R8");
  endtask

  task automatic wait_end(bit want_ok, string req, output int took);
    int d0, e0;
    d0 = n_done; e0 = n_err; took = 0;
    while (n_done == d0 && n_err == e0 && took < 20000) begin
      @(negedge clk); #2; took++;
    end
    repeat (20) @(negedge clk);
    #2;
    check((n_done - d0) == (want_ok ? 1 : 0), req, "done pulses", n_done - d0, want_ok ? 1 : 0);
    check((n_err - e0) == (want_ok ? 0 : 1), "R7", "lock_err pulses", n_err - e0, want_ok ? 0 : 1);
    check(exp_q.size() == 0, req, "expected transactions left", exp_q.size(), 0);
    check(busy == 1'b0, "R9", "idle after end", busy, 0);
    exp_q.delete();
  endtask

  initial begin
    int took;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #2;
    check(!busy && !bus_valid && !done && !lock_err, "R11", "reset state",
          {busy, bus_valid, done, lock_err}, 0);

    // R1 R3 R5 R6: cold non-USB bring-up, two polls
    polls_to_lock = 2;
    exp_bringup(0, 0, 8'd9, 7'd40, 2, 1);
    pulse(1, 0, 0, 8'd9, 7'd40, 16'd200);
    wait_end(1, "R6", took);
    check(cfg0_m == (EN3 | 32'd9) && cfg1_m == 32'd40, "R5", "bank contents", cfg0_m, EN3 | 32'd9);

    // R2: already locked with matching fields
    polls_to_lock = 0;
    push(1, T_SEL, 32'h0, "R1"); push(0, T_C0, 0, "R2"); push(0, T_C1, 0, "R2"); push(0, T_ST, 0, "R2");
    pulse(1, 0, 0, 8'd9, 7'd40, 16'd200);
    wait_end(1, "R2", took);
    check(took < 30, "R2", "early exit latency", took, 30);

    // R2: locked but multiplier differs -> full sequence, one poll
    polls_to_lock = 0;
    exp_bringup(0, 0, 8'd9, 7'd41, 1, 1);
    pulse(1, 0, 0, 8'd9, 7'd41, 16'd200);
    wait_end(1, "R2", took);

    // R4 R9: USB-PHY type on index 1, stray requests during the waits
    polls_to_lock = 1;
    exp_bringup(1, 1, 8'd1, 7'd39, 1, 1);
    pulse(1, 1, 1, 8'd1, 7'd39, 16'd200);
    repeat (500) @(negedge clk);
    start = 1; tgt_div = 8'd77; @(negedge clk); start = 0;
    stop = 1; @(negedge clk); stop = 0;
    check(busy == 1'b1, "R9", "busy inside analog wait", busy, 1);
    wait_end(1, "R9", took);
    check(t_vr - t_bg >= WAITC && t_vr - t_bg <= WAITC + 10, "R4", "bandgap to regulator gap", t_vr - t_bg, WAITC);
    check(t_cm - t_vr >= WAITC && t_cm - t_vr <= WAITC + 10, "R4", "regulator to commit gap", t_cm - t_vr, WAITC);

    // R8: USB-PHY shutdown
    exp_shutdown(1, 1);
    pulse(0, 1, 1, 8'd0, 7'd0, 16'd0);
    wait_end(1, "R8", took);
    check(cfg0_m[26:25] == 2'b00 && ana_m[1:0] == 2'b00, "R8", "enables cleared",
          {cfg0_m[26:25], ana_m[1:0]}, 0);

    // R8 R10: non-USB shutdown under back-pressure and slow responses
    stall_mod = 3; lat = 3;
    cfg0_m = EN3 | 32'd5; ana_m = ANA_D | 32'h3;
    exp_shutdown(0, 0);
    pulse(0, 0, 0, 8'd0, 7'd0, 16'd0);
    wait_end(1, "R10", took);
    check(ana_m[1:0] == 2'b11, "R8", "analog untouched for plain PLL", ana_m[1:0], 3);

    // R10: bring-up under back-pressure
    polls_to_lock = 1;
    exp_bringup(1, 0, 8'd3, 7'd20, 1, 1);
    pulse(1, 1, 0, 8'd3, 7'd20, 16'd200);
    wait_end(1, "R10", took);
    stall_mod = 0; lat = 1;

    // R7: lock never arrives
    polls_to_lock = -1; skip_status = 1;
    exp_bringup(0, 0, 8'd2, 7'd10, 0, 0);
    pulse(1, 0, 0, 8'd2, 7'd10, 16'd30);
    wait_end(0, "R7", took);
    check(took > 30, "R7", "timeout elapsed", took, 30);
    skip_status = 0;

    // R7: new start accepted after the error
    polls_to_lock = 1;
    exp_bringup(0, 0, 8'd2, 7'd11, 1, 1);
    pulse(1, 0, 0, 8'd2, 7'd11, 16'd30);
    wait_end(1, "R7", took);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule